// File: doc/BRIEF.md
# Ethernet DMA Control Register File

This block is the software-visible control and status register file of a multi-ring Ethernet DMA engine. A host reaches it through a simple single-port bus: valid, write enable, a 12-bit byte address over a 4 KB window, 32-bit write data and registered read data. Only whole 32-bit words are accessed. The word index is the byte address shifted right by two, and the low two address bits are ignored.

The file holds an interrupt event register, an interrupt mask register, a transmit halt register and a receive halt register. It also holds eight transmit and eight receive ring base registers, each with a current-descriptor pointer shadow. The ring engines, management interface and frame datapath are not part of the block. They reach it only through event-set inputs and halt-set inputs. The block drives per-ring restart pulses back to them, plus three level interrupt lines for transmit, receive and error. Writes to the halt registers restart rings as a side effect. Writing a ring base also reloads that ring's pointer.

Register word indices: 0 event (write-1-to-clear), 1 mask (read/write), 4 transmit halt, 5 receive halt, 64+n transmit base n, 72+n transmit pointer n (read-only), 96+n receive base n, 104+n receive pointer n (read-only). Every other index is unknown.

Top module: `eth_dma_regfile`

## Requirements
- R1: A read with bus_valid=1 and bus_we=0 loads bus_rdata at the next clock edge with the register at word index bus_addr[11:2]. bus_rdata holds its value when there is no read. Unknown indices read zero.
- R2: Each 1 written to the event register (index 0) clears that bit. evt_set bits are ORed into the event register at the same edge. When a set and a clear hit the same bit in one cycle, the set wins.
- R3: A write to the mask register (index 1) stores the written value directly, and reads return it.
- R4: With active = event AND mask, irq_tx is the OR of active[7:0], irq_rx is the OR of active[15:8], and irq_err is the OR of active[31:16]. The lines follow the registers with no further delay.
- R5: In the transmit halt register (index 4), ring i is bit 31-i. A write pulses tx_restart[i] high for exactly the next cycle for every written 1, whatever the stored bit holds. Written 1s then clear the stored bits. tx_halt_set[i] sets bit 31-i and wins over a same-cycle clear.
- R6: In the receive halt register (index 5), ring i is bit 23-i. rx_restart[i] pulses for one cycle only if the written bit is 1 and the stored bit was 0 before the write. Written 1s clear the stored bits, and rx_halt_set[i] sets bit 23-i, winning over a clear.
- R7: A write to transmit base n (index 64+n) or receive base n (index 96+n) stores the data with bits [2:0] forced to zero. It also loads that same aligned value into pointer n (index 72+n or 104+n).
- R8: Writes to the read-only pointer indices and to unknown indices change no register. Reads of unknown indices return zero.
- R9: After reset, all registers read zero, all interrupt lines are low and no restart pulse is active.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_valid | input | 1 | Access request this cycle |
| bus_we | input | 1 | 1 write, 0 read |
| bus_addr | input | 12 | Byte address, word index in [11:2] |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data |
| evt_set | input | 32 | Hardware event set bits |
| tx_halt_set | input | 8 | Transmit ring halted, one bit per ring |
| rx_halt_set | input | 8 | Receive ring halted, one bit per ring |
| tx_restart | output | 8 | One-cycle transmit ring restart pulses |
| rx_restart | output | 8 | One-cycle receive ring restart pulses |
| irq_tx | output | 1 | Transmit interrupt level |
| irq_rx | output | 1 | Receive interrupt level |
| irq_err | output | 1 | Error interrupt level |

## Verification
A wrong event or mask bit shows on an interrupt line in the same cycle that the bad state is stored. It shows in bus_rdata one cycle after the next read of that register. A wrong stored halt bit on the receive side shows as a missing or extra rx_restart pulse on the following write. A wrong bit on the transmit side shows only through a read-back. A bad base or pointer copy stays hidden until software reads it, so the bench reads every base and pointer after writing them. It compares all outputs against its model on every clock, so any divergence is reported within one cycle of reaching a port.

// File: rtl/eth_dma_regfile.sv
module eth_dma_regfile #(
  parameter int          DW        = 32,
  parameter int          AW        = 12,
  parameter int          NRING     = 8,
  parameter logic [31:0] TX_GROUP  = 32'h0000_00FF,
  parameter logic [31:0] RX_GROUP  = 32'h0000_FF00,
  parameter logic [31:0] ERR_GROUP = 32'hFFFF_0000,
  parameter int          EVT_IDX   = 0,
  parameter int          MSK_IDX   = 1,
  parameter int          TXH_IDX   = 4,
  parameter int          RXH_IDX   = 5,
  parameter int          TXB_IDX   = 64,
  parameter int          TXP_IDX   = 72,
  parameter int          RXB_IDX   = 96,
  parameter int          RXP_IDX   = 104
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          bus_valid,
  input  logic          bus_we,
  input  logic [AW-1:0] bus_addr,
  input  logic [DW-1:0] bus_wdata,
  output logic [DW-1:0] bus_rdata,
  input  logic [DW-1:0] evt_set,
  input  logic [NRING-1:0] tx_halt_set,
  input  logic [NRING-1:0] rx_halt_set,
  output logic [NRING-1:0] tx_restart,
  output logic [NRING-1:0] rx_restart,
  output logic          irq_tx,
  output logic          irq_rx,
  output logic          irq_err
);
  localparam int IW      = AW - 2;
  localparam int TXH_TOP = DW - 1;
  localparam int RXH_TOP = DW - 9;

  logic [IW-1:0]    idx;
  logic             wr, rd;
  logic [DW-1:0]    evt_q, mask_q, rd_val;
  logic [NRING-1:0] txh_q, rxh_q, tx_wbits, rx_wbits;
  logic [DW-1:0]    txb_q [NRING];
  logic [DW-1:0]    txp_q [NRING];
  logic [DW-1:0]    rxb_q [NRING];
  logic [DW-1:0]    rxp_q [NRING];
  logic [DW-1:0]    aligned;

  assign idx     = bus_addr[AW-1:2];
  assign wr      = bus_valid && bus_we;
  assign rd      = bus_valid && !bus_we;
  assign aligned = {bus_wdata[DW-1:3], 3'b000};

  wire wr_evt = wr && (idx == IW'(EVT_IDX));
  wire wr_msk = wr && (idx == IW'(MSK_IDX));
  wire wr_txh = wr && (idx == IW'(TXH_IDX));
  wire wr_rxh = wr && (idx == IW'(RXH_IDX));

  always_comb begin
    for (int i = 0; i < NRING; i++) begin
      tx_wbits[i] = bus_wdata[TXH_TOP-i];
      rx_wbits[i] = bus_wdata[RXH_TOP-i];
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      evt_q      <= '0;
      mask_q     <= '0;
      txh_q      <= '0;
      rxh_q      <= '0;
      tx_restart <= '0;
      rx_restart <= '0;
    end else begin
      evt_q      <= (evt_q & ~(wr_evt ? bus_wdata : '0)) | evt_set;
      if (wr_msk) mask_q <= bus_wdata;
      txh_q      <= (txh_q & ~(wr_txh ? tx_wbits : '0)) | tx_halt_set;
      rxh_q      <= (rxh_q & ~(wr_rxh ? rx_wbits : '0)) | rx_halt_set;
      tx_restart <= wr_txh ? tx_wbits : '0;
      rx_restart <= wr_rxh ? (rx_wbits & ~rxh_q) : '0;
    end
  end

  for (genvar g = 0; g < NRING; g++) begin : g_ring
    wire hit_tb = wr && (idx == IW'(TXB_IDX + g));
    wire hit_rb = wr && (idx == IW'(RXB_IDX + g));
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        txb_q[g] <= '0;
        txp_q[g] <= '0;
        rxb_q[g] <= '0;
        rxp_q[g] <= '0;
      end else begin
        if (hit_tb) begin
          txb_q[g] <= aligned;
          txp_q[g] <= aligned;
        end
        if (hit_rb) begin
          rxb_q[g] <= aligned;
          rxp_q[g] <= aligned;
        end
      end
    end
  end

  always_comb begin
    rd_val = '0;
    if (idx == IW'(EVT_IDX)) rd_val = evt_q;
    if (idx == IW'(MSK_IDX)) rd_val = mask_q;
    for (int i = 0; i < NRING; i++) begin
      if (idx == IW'(TXH_IDX)) rd_val[TXH_TOP-i] = txh_q[i];
      if (idx == IW'(RXH_IDX)) rd_val[RXH_TOP-i] = rxh_q[i];
      if (idx == IW'(TXB_IDX + i)) rd_val = txb_q[i];
      if (idx == IW'(TXP_IDX + i)) rd_val = txp_q[i];
      if (idx == IW'(RXB_IDX + i)) rd_val = rxb_q[i];
      if (idx == IW'(RXP_IDX + i)) rd_val = rxp_q[i];
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n)  bus_rdata <= '0;
    else if (rd) bus_rdata <= rd_val;
  end

  wire [DW-1:0] active = evt_q & mask_q;
  assign irq_tx  = |(active & TX_GROUP);
  assign irq_rx  = |(active & RX_GROUP);
  assign irq_err = |(active & ERR_GROUP);

  logic ptr_low;
  always_comb begin
    ptr_low = 1'b0;
    for (int i = 0; i < NRING; i++)
      ptr_low = ptr_low | (|txp_q[i][2:0]) | (|rxp_q[i][2:0]) |
                (|txb_q[i][2:0]) | (|rxb_q[i][2:0]);
  end

  p_set_wins_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (|evt_set) |=> ((evt_q & $past(evt_set)) == $past(evt_set)));

  p_masked_quiet_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (mask_q == '0) |-> (!irq_tx && !irq_rx && !irq_err));

  p_tx_pulse_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_txh |=> (tx_restart == '0));

  p_rx_only_idle_r6: assert property (@(posedge clk) disable iff (!rst_n)
    wr_rxh |=> ((rx_restart & $past(rxh_q)) == '0));

  p_aligned_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !ptr_low);

  p_hold_rdata_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !rd |=> $stable(bus_rdata));
endmodule

// File: tb/eth_dma_regfile_tb.sv
module eth_dma_regfile_tb;
  localparam int CLK_PERIOD = 10;

  logic        clk = 0, rst_n = 0;
  logic        bus_valid = 0, bus_we = 0;
  logic [11:0] bus_addr = '0;
  logic [31:0] bus_wdata = '0, evt_set = '0;
  logic [7:0]  tx_halt_set = '0, rx_halt_set = '0;
  logic [31:0] bus_rdata;
  logic [7:0]  tx_restart, rx_restart;
  logic        irq_tx, irq_rx, irq_err;

  eth_dma_regfile u_dut (
    .clk(clk), .rst_n(rst_n), .bus_valid(bus_valid), .bus_we(bus_we),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .evt_set(evt_set), .tx_halt_set(tx_halt_set), .rx_halt_set(rx_halt_set),
    .tx_restart(tx_restart), .rx_restart(rx_restart),
    .irq_tx(irq_tx), .irq_rx(irq_rx), .irq_err(irq_err));

  always #(CLK_PERIOD/2) clk = ~clk;

  int vectors = 0, fails = 0, cycles = 0;
  string phase = "R9";

  // Behavioural reference model
  logic [31:0] m_evt, m_mask, m_rdata;
  logic [7:0]  m_txh, m_rxh, m_txr, m_rxr;
  logic [31:0] m_tb [8], m_tp [8], m_rb [8], m_rp [8];

  function automatic logic [31:0] m_read(int w);
    logic [31:0] v = 0;
    if (w == 0) v = m_evt;
    else if (w == 1) v = m_mask;
    else if (w == 4) for (int i = 0; i < 8; i++) v[31-i] = m_txh[i];
    else if (w == 5) for (int i = 0; i < 8; i++) v[23-i] = m_rxh[i];
    else if (w >= 64 && w < 72) v = m_tb[w-64];
    else if (w >= 72 && w < 80) v = m_tp[w-72];
    else if (w >= 96 && w < 104) v = m_rb[w-96];
    else if (w >= 104 && w < 112) v = m_rp[w-104];
    return v;
  endfunction

  always @(posedge clk) begin
    int w;
    logic [31:0] d, al;
    w = int'(bus_addr >> 2);
    d = bus_wdata;
    al = {d[31:3], 3'b000};
    if (!rst_n) begin
      m_evt = 0; m_mask = 0; m_rdata = 0; m_txh = 0; m_rxh = 0;
      m_txr = 0; m_rxr = 0;
      for (int i = 0; i < 8; i++) begin
        m_tb[i] = 0; m_tp[i] = 0; m_rb[i] = 0; m_rp[i] = 0;
      end
    end else begin
      m_txr = 0; m_rxr = 0;
      if (bus_valid && !bus_we) m_rdata = m_read(w);
      if (bus_valid && bus_we) begin
        if (w == 0) m_evt = m_evt & ~d;
        else if (w == 1) m_mask = d;
        else if (w == 4) begin
          for (int i = 0; i < 8; i++) if (d[31-i]) begin
            m_txr[i] = 1; m_txh[i] = 0;
          end
        end else if (w == 5) begin
          for (int i = 0; i < 8; i++) if (d[23-i]) begin
            m_rxr[i] = !m_rxh[i]; m_rxh[i] = 0;
          end
        end
        else if (w >= 64 && w < 72) begin m_tb[w-64] = al; m_tp[w-64] = al; end
        else if (w >= 96 && w < 104) begin m_rb[w-96] = al; m_rp[w-96] = al; end
      end
      m_evt = m_evt | evt_set;
      m_txh = m_txh | tx_halt_set;
      m_rxh = m_rxh | rx_halt_set;
    end
  end

  task automatic check(string tag, string what, logic [31:0] act, logic [31:0] exp);
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual %h expected %h (cycle %0d)", tag, what, act, exp, cycles);
    end
  endtask

  always @(negedge clk) begin
    logic [31:0] a;
    a = m_evt & m_mask;
    vectors++;
    check(phase == "" ? "R1" : phase, "rdata (R1)", bus_rdata, m_rdata);
    check(phase, "irq_tx (R4)", {31'b0, irq_tx}, {31'b0, |a[7:0]});
    check(phase, "irq_rx (R4)", {31'b0, irq_rx}, {31'b0, |a[15:8]});
    check(phase, "irq_err (R4)", {31'b0, irq_err}, {31'b0, |a[31:16]});
    check(phase, "tx_restart (R5)", {24'b0, tx_restart}, {24'b0, m_txr});
    check(phase, "rx_restart (R6)", {24'b0, rx_restart}, {24'b0, m_rxr});
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 100000) begin
      fails++;
      $display("FAIL watchdog: actual %0d cycles expected fewer", cycles);
      $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
    end
  end

  task automatic step(logic v, logic we, int w, logic [31:0] d);
    @(posedge clk); #1;
    bus_valid = v; bus_we = we; bus_addr = 12'(w * 4); bus_wdata = d;
  endtask
  task automatic wr(int w, logic [31:0] d); step(1, 1, w, d); endtask
  task automatic rd(int w); step(1, 0, w, 0); endtask
  task automatic idle(); step(0, 0, 0, 0); evt_set = 0; tx_halt_set = 0; rx_halt_set = 0; endtask

  initial begin
    // R9: reset state
    repeat (3) @(posedge clk);
    #1 rst_n = 1;
    rd(0); rd(1); rd(4); rd(5); rd(72); idle();

    phase = "R3";
    wr(1, 32'h0101_0101); rd(1); idle();

    phase = "R2";
    step(0, 0, 0, 0); evt_set = 32'h8001_0203; idle();
    rd(0);
    wr(0, 32'h0000_0003); evt_set = 32'h0000_0001; idle(); rd(0); idle();
    wr(0, 32'hFFFF_FFFF); idle(); rd(0); idle();

    phase = "R4";
    wr(1, 32'hFFFF_FFFF);
    step(0, 0, 0, 0); evt_set = 32'h0000_0080; idle();
    step(0, 0, 0, 0); evt_set = 32'h0000_4000; idle();
    step(0, 0, 0, 0); evt_set = 32'h0002_0000; idle();
    wr(1, 32'h0000_0000); idle(); wr(1, 32'h0000_FF00); idle();
    wr(0, 32'hFFFF_FFFF); idle();

    phase = "R5";
    step(0, 0, 0, 0); tx_halt_set = 8'h05; idle(); rd(4);
    wr(4, 32'hC000_0000); idle(); rd(4);
    wr(4, 32'h2000_0000); tx_halt_set = 8'h04; idle(); rd(4); idle();

    phase = "R6";
    step(0, 0, 0, 0); rx_halt_set = 8'h03; idle(); rd(5);
    wr(5, 32'h00E0_0000); idle(); rd(5);
    wr(5, 32'h00FF_0000); idle(); rd(5); idle();

    phase = "R7";
    for (int i = 0; i < 8; i++) begin
      wr(64 + i, 32'h1000_0007 + 32'(i * 16));
      wr(96 + i, 32'h2000_00FD + 32'(i * 32));
    end
    for (int i = 0; i < 8; i++) begin
      rd(64 + i); rd(72 + i); rd(96 + i); rd(104 + i);
    end
    idle();

    phase = "R8";
    wr(72, 32'hDEAD_BEEF); wr(105, 32'h1234_5678); wr(3, 32'hFFFF_FFFF);
    wr(1023, 32'hFFFF_FFFF); rd(72); rd(105); rd(3); rd(1023); rd(2); idle();

    phase = "R1";
    for (int n = 0; n < 600; n++) begin
      int pick = $urandom_range(0, 15);
      int w;
      case (pick % 8)
        0: w = 0; 1: w = 1; 2: w = 4; 3: w = 5;
        4: w = 64 + $urandom_range(0, 15);
        5: w = 96 + $urandom_range(0, 15);
        6: w = $urandom_range(0, 1023);
        default: w = 2;
      endcase
      step($urandom_range(0, 3) != 0, $urandom_range(0, 1) == 1, w, $urandom());
      evt_set = ($urandom_range(0, 3) == 0) ? $urandom() & $urandom() : 0;
      tx_halt_set = ($urandom_range(0, 3) == 0) ? 8'($urandom()) : 0;
      rx_halt_set = ($urandom_range(0, 3) == 0) ? 8'($urandom()) : 0;
    end
    idle();

    phase = "R9";
    step(0, 0, 0, 0); rst_n = 0; idle(); #1 rst_n = 1;
    rd(0); rd(64); rd(104); idle(); idle();

    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end
endmodule